// File: doc/BRIEF.md
# Real-Time Clock Seconds Core with Read Snapshot

This block keeps time of day for a chip that receives a 32768 Hz clock enable from a low-frequency oscillator domain that has already been synchronised. A 15-bit divider counts the oscillator ticks. Each time the divider wraps, it advances a packed-BCD time of day made of seconds, minutes and hours in 24-hour form. The upper half of each divider cycle drives a 1 Hz square wave. Any write to the seconds field restarts the divider, so software sets the phase of that wave at the moment it sets the clock.

Software reaches the block through a byte-wide register port. The port has an address pointer that steps forward after each byte. Reads of the time fields return a captured copy, not the running counters. The copy is taken when a start strobe arrives or when the pointer steps from its last address back to the first. Because of this, a second boundary that falls in the middle of a three-byte read cannot mix old and new fields. The port also holds a control byte whose low bit gates the square wave, and a signed aging-offset byte that is stored and returned unchanged.

Top module: `rtc_sec_core`

## Requirements
- R1: After synchronous reset the time reads 00:00:00, the divider is zero, sqw_out is low, rd_data is 0x00, the control byte reads 0x01 and the aging byte reads 0x00.
- R2: Address map: 0x00 seconds (7 bits), 0x01 minutes (7 bits), 0x02 hours (6 bits), 0x0E control (bit 0 = square-wave enable, other bits read 0), 0x10 aging offset (8 bits). Every other address from 0x00 to 0x12 reads 0x00 and ignores writes. A write reaches the live register on the clock edge that samples wr_stb.
- R3: ptr_ld loads the pointer from ptr_val. Each accepted read or write byte then advances the pointer by one, and 0x12 is followed by 0x00. When strobes coincide, ptr_ld wins over wr_stb, and wr_stb wins over rd_stb.
- R4: The divider advances once per cycle with tick_en high. It wraps after 32768 ticks, and each wrap is one second. A write to address 0x00 clears the divider to zero.
- R5: With the output enabled, sqw_out rises exactly 16384 ticks after a seconds write and falls exactly 32768 ticks after it.
- R6: The falling edge of sqw_out happens on the same clock edge as the seconds increment. A snapshot taken after that edge shows the new second.
- R7: Seconds and minutes count 00 to 59 in BCD, and hours count 00 to 23. A wrap of one field carries into the next, so 23:59:59 is followed by 00:00:00 and 09:59:59 by 10:00:00.
- R8: The time fields are read from a snapshot. The snapshot is refreshed by start_stb or by a pointer step from 0x12 to 0x00, and by nothing else; a pointer load to 0x00 does not refresh it. The live counters keep running while the snapshot is held.
- R9: If a write to a time address lands on the same edge as a second tick, the written value is stored and that tick advances no time field.
- R10: While control bit 0 is 0, sqw_out is held low but the divider keeps counting. Setting the bit again shows the current divider phase at once.
- R11: The aging byte is an 8-bit two's-complement value that reads back exactly as written. For example, 0xF1 reads back as -15.
- R12: rd_data is registered. It carries the addressed byte from the cycle after rd_stb and holds that value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32768 Hz oscillator tick enable, one cycle per tick |
| start_stb | input | 1 | Transfer start; captures the live time into the snapshot |
| ptr_ld | input | 1 | Load the address pointer from ptr_val |
| ptr_val | input | 5 | Pointer load value |
| wr_stb | input | 1 | Write wr_data at the pointer, then advance the pointer |
| wr_data | input | 8 | Write byte |
| rd_stb | input | 1 | Read the byte at the pointer, then advance the pointer |
| rd_data | output | 8 | Registered read byte |
| sqw_out | output | 1 | 1 Hz square wave |

## Verification
A register write takes effect on the edge that samples wr_stb. rd_data is valid one cycle after rd_stb. sqw_out follows the divider state with no extra register, so an edge shows up on the same clock edge as the tick that causes it. The bench changes inputs on the falling clock edge and samples outputs there too. To measure the square-wave timing it counts tick cycles from the seconds-write edge one at a time and compares the counts against 16384 and 32768. To catch a torn read, it places a single tick between the bytes of a snapshot read and confirms that all three bytes come from before the tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_SEC  = 5'h00;
    localparam logic [ADDR_W-1:0] A_MIN  = 5'h01;
    localparam logic [ADDR_W-1:0] A_HR   = 5'h02;
    localparam logic [ADDR_W-1:0] A_CTRL = 5'h0E;
    localparam logic [ADDR_W-1:0] A_AGE  = 5'h10;
    localparam logic [ADDR_W-1:0] A_LAST = 5'h12;

    localparam logic [6:0] LIM_MS = 7'h59;
    localparam logic [6:0] LIM_HR = 7'h23;
    localparam logic [6:0] HR_MASK = 7'h3F;

    typedef enum logic [1:0] {
        FLD_SEC = 2'd0,
        FLD_MIN = 2'd1,
        FLD_HR  = 2'd2
    } field_e;

    typedef struct packed {
        logic [6:0] hr;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    // Returns {wrapped, next} for a packed-BCD field with inclusive limit lim.
    function automatic logic [7:0] bcd_step(input logic [6:0] v, input logic [6:0] lim);
        logic [7:0] r;
        if (v >= lim)
            r = {1'b1, 7'h00};
        else if (v[3:0] >= 4'd9)
            r = {1'b0, v[6:4] + 3'd1, 4'd0};
        else
            r = {1'b0, v + 7'd1};
        return r;
    endfunction

    function automatic logic bcd_ok(input logic [6:0] v, input logic [6:0] lim);
        return (v[3:0] <= 4'd9) && (v <= lim);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic clr,
    output logic sec_tick,
    output logic half_hi
);
    localparam logic [PRE_W-1:0] CNT_TOP = '1;

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick_en)
            cnt_q <= cnt_q + 1'b1;
    end

    assign sec_tick = tick_en && (cnt_q == CNT_TOP);
    assign half_hi  = cnt_q[PRE_W-1];

    AST_HALF_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(half_hi) |-> $past(tick_en)) else $error("half phase rose without a tick"); // R4

endmodule

// File: rtl/rtc_time_ctr.sv
module rtc_time_ctr
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  field_e     wr_fld,
    input  logic [6:0] wr_val,
    output rtc_time_t  now
);
    rtc_time_t  cur_q;
    logic [7:0] s_nx, m_nx, h_nx;

    always_comb begin
        s_nx = bcd_step(cur_q.sec, LIM_MS);
        m_nx = bcd_step(cur_q.min, LIM_MS);
        h_nx = bcd_step(cur_q.hr,  LIM_HR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (wr_en) begin
            case (wr_fld)
                FLD_SEC: cur_q.sec <= wr_val;
                FLD_MIN: cur_q.min <= wr_val;
                FLD_HR:  cur_q.hr  <= wr_val & HR_MASK;
                default: ;
            endcase
        end else if (tick) begin
            cur_q.sec <= s_nx[6:0];
            if (s_nx[7])
                cur_q.min <= m_nx[6:0];
            if (s_nx[7] && m_nx[7])
                cur_q.hr <= h_nx[6:0];
        end
    end

    assign now = cur_q;

    AST_SEC_STAYS_BCD: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && bcd_ok(cur_q.sec, LIM_MS)) |=> bcd_ok(cur_q.sec, LIM_MS)) else $error("seconds left BCD range"); // R7
    AST_SEC_WRITE_STORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_fld == FLD_SEC) |=> (cur_q.sec == $past(wr_val))) else $error("seconds write lost"); // R9
    AST_OTHER_WRITE_FREEZES_SEC: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_fld != FLD_SEC) |=> $stable(cur_q.sec)) else $error("tick not discarded on write"); // R9

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_stb,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic              wr_stb,
    input  logic [7:0]        wr_data,
    input  logic              rd_stb,
    input  rtc_time_t         now,
    output logic [7:0]        rd_data,
    output logic              sq_en,
    output logic              tm_wr_en,
    output field_e            tm_wr_fld,
    output logic [6:0]        tm_wr_val,
    output logic              sec_clr
);
    logic [ADDR_W-1:0] ptr_q, ptr_nx;
    rtc_time_t         snap_q;
    logic              en_q;
    logic [7:0]        age_q;
    logic [7:0]        rd_q;
    logic [7:0]        rd_mux;
    logic              do_wr, do_rd, step, wrap;

    always_comb begin
        do_wr  = wr_stb && !ptr_ld;
        do_rd  = rd_stb && !ptr_ld && !wr_stb;
        step   = do_wr || do_rd;
        wrap   = step && (ptr_q == A_LAST);
        ptr_nx = (ptr_q == A_LAST) ? '0 : ptr_q + 1'b1;

        tm_wr_en  = do_wr && (ptr_q <= A_HR);
        tm_wr_fld = field_e'(ptr_q[1:0]);
        tm_wr_val = wr_data[6:0];
        sec_clr   = do_wr && (ptr_q == A_SEC);

        case (ptr_q)
            A_SEC:   rd_mux = {1'b0, snap_q.sec};
            A_MIN:   rd_mux = {1'b0, snap_q.min};
            A_HR:    rd_mux = {1'b0, snap_q.hr};
            A_CTRL:  rd_mux = {7'b0, en_q};
            A_AGE:   rd_mux = age_q;
            default: rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            snap_q <= '0;
            en_q   <= 1'b1;
            age_q  <= 8'h00;
            rd_q   <= 8'h00;
        end else begin
            if (ptr_ld)
                ptr_q <= ptr_val;
            else if (step)
                ptr_q <= ptr_nx;

            if (start_stb || wrap)
                snap_q <= now;

            if (do_wr && ptr_q == A_CTRL)
                en_q <= wr_data[0];
            if (do_wr && ptr_q == A_AGE)
                age_q <= wr_data;

            if (do_rd)
                rd_q <= rd_mux;
        end
    end

    assign rd_data = rd_q;
    assign sq_en   = en_q;

    AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (rst)
        ((rd_stb || wr_stb) && !ptr_ld && ptr_q == A_LAST) |=> (ptr_q == '0)) else $error("pointer did not wrap"); // R3
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!start_stb && !((rd_stb || wr_stb) && !ptr_ld && ptr_q == A_LAST)) |=> $stable(snap_q)) else $error("snapshot changed without trigger"); // R8
    AST_RD_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_q)) else $error("read data moved without read"); // R12

endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
    import rtc_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              start_stb,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic              wr_stb,
    input  logic [7:0]        wr_data,
    input  logic              rd_stb,
    output logic [7:0]        rd_data,
    output logic              sqw_out
);
    rtc_time_t  now;
    logic       sec_tick, half_hi, sq_en;
    logic       tm_wr_en, sec_clr;
    field_e     tm_wr_fld;
    logic [6:0] tm_wr_val;

    rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .clr      (sec_clr),
        .sec_tick (sec_tick),
        .half_hi  (half_hi)
    );

    rtc_time_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .tick   (sec_tick),
        .wr_en  (tm_wr_en),
        .wr_fld (tm_wr_fld),
        .wr_val (tm_wr_val),
        .now    (now)
    );

    rtc_regport u_port (
        .clk       (clk),
        .rst       (rst),
        .start_stb (start_stb),
        .ptr_ld    (ptr_ld),
        .ptr_val   (ptr_val),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_stb    (rd_stb),
        .now       (now),
        .rd_data   (rd_data),
        .sq_en     (sq_en),
        .tm_wr_en  (tm_wr_en),
        .tm_wr_fld (tm_wr_fld),
        .tm_wr_val (tm_wr_val),
        .sec_clr   (sec_clr)
    );

    assign sqw_out = sq_en & half_hi;

    AST_SET_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        sec_clr |=> !sqw_out) else $error("square wave not restarted by seconds write"); // R5
    AST_FALL_IS_TICK: assert property (@(posedge clk) disable iff (rst)
        ($fell(sqw_out) && sq_en && $past(sq_en) && !$past(tm_wr_en)) |-> (now.sec != $past(now.sec))) else $error("falling edge without second increment"); // R6

endmodule

// File: tb/rtc_sec_core_tb.sv
module rtc_sec_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0, start_stb = 1'b0, ptr_ld = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [4:0] ptr_val = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sqw_out;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    rtc_sec_core u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .start_stb(start_stb),
        .ptr_ld(ptr_ld), .ptr_val(ptr_val), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .sqw_out(sqw_out)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setptr(input logic [4:0] a);
        ptr_ld = 1'b1; ptr_val = a;
        cyc();
        ptr_ld = 1'b0;
    endtask

    task automatic wr_here(input logic [7:0] d, input logic tk);
        wr_stb = 1'b1; wr_data = d; tick_en = tk;
        cyc();
        wr_stb = 1'b0; tick_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic tk);
        setptr(a);
        wr_here(d, tk);
    endtask

    task automatic rd(output logic [7:0] d);
        rd_stb = 1'b1;
        cyc();
        rd_stb = 1'b0;
        d = rd_data;
    endtask

    task automatic snap();
        start_stb = 1'b1;
        cyc();
        start_stb = 1'b0;
    endtask

    task automatic read_time(output logic [7:0] s, output logic [7:0] m, output logic [7:0] h);
        setptr(5'h00);
        snap();
        rd(s); rd(m); rd(h);
    endtask

    task automatic set_time(input int h, input int m, input int s);
        setptr(5'h00);
        wr_here(to_bcd(s), 1'b0);
        wr_here(to_bcd(m), 1'b0);
        wr_here(to_bcd(h), 1'b0);
    endtask

    task automatic run_ticks(input int n);
        tick_en = 1'b1;
        repeat (n) cyc();
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] s, m, h, d, held;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 sqw", sqw_out, 1'b0);
        read_time(s, m, h);
        chk("R1 sec", s, 8'h00);
        chk("R1 min", m, 8'h00);
        chk("R1 hr", h, 8'h00);
        setptr(5'h0E);
        rd(d); chk("R1 ctrl", d, 8'h01);
        rd(d); chk("R2 unused 0x0F", d, 8'h00);
        rd(d); chk("R1 aging", d, 8'h00);

        // R12 read data holds without a read
        held = rd_data;
        setptr(5'h01);
        repeat (3) cyc();
        chk("R12 rd_data held", rd_data, held);

        // R2 R3 random time write/readback through auto-increment
        for (int i = 0; i < 8; i++) begin
            int rh, rm, rs;
            rh = int'($urandom % 24);
            rm = int'($urandom % 60);
            rs = int'($urandom % 60);
            set_time(rh, rm, rs);
            read_time(s, m, h);
            chk("R2 sec readback", s, to_bcd(rs));
            chk("R2 min readback", m, to_bcd(rm));
            chk("R2 hr readback", h, to_bcd(rh));
        end

        // R11 aging two's complement
        wr(5'h10, 8'hF1, 1'b0);
        setptr(5'h10);
        rd(d);
        chk("R11 aging -15", 32'($signed(d)), 32'(-15));
        for (int i = 0; i < 6; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            wr(5'h10, v, 1'b0);
            setptr(5'h10);
            rd(d);
            chk("R11 aging random", d, v);
        end

        // R2 unused address ignores writes
        wr(5'h05, 8'hAA, 1'b0);
        setptr(5'h05);
        rd(d);
        chk("R2 unused write ignored", d, 8'h00);

        // R5 R6 R7 edge timing and rollover
        set_time(23, 59, 58);
        tick_en = 1'b1;
        n = 0;
        while (sqw_out !== 1'b1 && n < 40000) begin cyc(); n++; end
        chk("R5 rise tick count", n, 16384);
        while (sqw_out !== 1'b0 && n < 70000) begin cyc(); n++; end
        chk("R5 fall tick count", n, 32768);
        tick_en = 1'b0;
        read_time(s, m, h);
        chk("R6 sec after fall", s, 8'h59);
        chk("R6 min after fall", m, 8'h59);
        run_ticks(32768);
        chk("R4 one second later sqw low", sqw_out, 1'b0);
        read_time(s, m, h);
        chk("R7 rollover sec", s, 8'h00);
        chk("R7 rollover min", m, 8'h00);
        chk("R7 rollover hr", h, 8'h00);

        // R8 stale snapshot until wrap
        wr(5'h00, 8'h30, 1'b0);
        setptr(5'h00);
        rd(d);
        chk("R8 pointer load keeps snapshot", d, 8'h00);
        setptr(5'h12);
        rd(d);
        chk("R2 addr 0x12 reads zero", d, 8'h00);
        rd(d);
        chk("R3 R8 wrap refreshes snapshot", d, 8'h30);

        // R8 R6 R7 torn-read protection across a tick
        set_time(9, 59, 59);
        run_ticks(32767);
        setptr(5'h00);
        snap();
        rd(s);
        tick_en = 1'b1; cyc(); tick_en = 1'b0;
        rd(m);
        rd(h);
        chk("R8 snapshot sec pre-tick", s, 8'h59);
        chk("R8 snapshot min pre-tick", m, 8'h59);
        chk("R8 snapshot hr pre-tick", h, 8'h09);
        read_time(s, m, h);
        chk("R7 carry sec", s, 8'h00);
        chk("R7 carry min", m, 8'h00);
        chk("R7 carry hr", h, 8'h10);

        // R10 disabled output, divider keeps running
        wr(5'h00, 8'h10, 1'b0);
        wr(5'h0E, 8'h00, 1'b0);
        run_ticks(20000);
        chk("R10 held low while disabled", sqw_out, 1'b0);
        setptr(5'h0E);
        rd(d);
        chk("R10 ctrl reads 0", d, 8'h00);
        wr(5'h0E, 8'h01, 1'b0);
        chk("R10 phase kept on re-enable", sqw_out, 1'b1);

        // R9 write colliding with a tick
        run_ticks(12767);
        chk("R4 still high before wrap", sqw_out, 1'b1);
        wr(5'h01, 8'h42, 1'b1);
        read_time(s, m, h);
        chk("R9 tick discarded sec", s, 8'h10);
        chk("R9 written min wins", m, 8'h42);
        chk("R9 hr unchanged", h, 8'h10);

        done = 1'b1;
        report();
        $finish;
    end
endmodule